// File: doc/BRIEF.md
# Two-Level IOMMU Translation Walker

This block turns a device-side virtual address, tagged with a stream number, into a physical address. It walks a two-level table of 64-bit descriptors that sits in memory behind a simple one-beat read port. A request carries a stream, an address and a read/write flag. The walker handles one request at a time and answers with one response pulse. The response carries either the translated address or a fault with a cause code.

Each stream has a bypass bit, a translate-enable bit and four table base words. These are presented to the block as flat input vectors. Pages are 16 KiB, and a table page holds 2048 eight-byte descriptors. Each leaf descriptor can narrow the accessible part of its page to a window of 4-byte granules. An access outside that window faults, unless the descriptor marks the whole page as accessible.

The virtual address is 38 bits wide and splits as follows:
- bits 37:36 pick one of the stream's base words;
- bits 35:25 index the first-level table;
- bits 24:14 index the leaf table;
- bits 13:0 are the offset within the page.

Top module: `iommu_walker`

## Requirements
- R1: After reset, `reqReady` is 1, and `rspValid` and `memRdEn` are 0.
- R2: If the stream's bypass bit is set, whatever its enable bit, the response has no fault and `rspAddr` equals the request address zero-extended. No memory read is made, and `rspValid` rises two cycles after the cycle in which the request is accepted.
- R3: If the stream has neither bypass nor enable set, the response faults with cause 6 after the same two cycles, with no memory read.
- R4: Address bits 37:36 select base word `tableBase[(stream*4+sel)*32 +: 32]`. Bit 31 of that word is its valid flag, and bits 27:0 hold the first-level table address shifted right by 12. If the word is not valid, the response faults with cause 1 and no memory read is made.
- R5: The first-level descriptor is read at base + bits 35:25 × 8. It is valid only when its bits 1:0 equal 2'b11; otherwise the response faults with cause 2. Its bits 39:14 give the leaf table page.
- R6: The leaf descriptor is read at leaf table + bits 24:14 × 8. If its bit 0 is clear, the response faults with cause 3.
- R7: A valid, in-window leaf gives `rspAddr` = {descriptor bits 39:14, address bits 13:0} with cause 0.
- R8: If address bits 13:2 are below descriptor bits 63:52 (start) or above bits 51:40 (end), both limits inclusive, the access faults. The cause is 4 for a read and 5 for a write (`reqWrite`=1).
- R9: When leaf descriptor bit 1 (full page) is set, the start and end window is ignored.
- R10: `reqReady` is high only when the walker is idle. Each accepted request gets exactly one single-cycle `rspValid` pulse. `memRdEn` comes as single-cycle pulses, two for a request that reaches a leaf and one for a first-level fault.
- R11: On any fault, `rspFault`=1 and `rspAddr` is the zero-extended request address. On success, `rspFault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Walker idle, request taken this cycle |
| reqStream | input | SID_W | Stream number |
| reqAddr | input | 38 | Device virtual address |
| reqWrite | input | 1 | 1 = write access, 0 = read |
| bypassEn | input | NUM_STREAMS | Per-stream bypass |
| xlateEn | input | NUM_STREAMS | Per-stream translate enable |
| tableBase | input | NUM_STREAMS*128 | Four 32-bit base words per stream |
| memRdEn | output | 1 | Descriptor read strobe |
| memRdAddr | output | PA_W | Descriptor byte address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 64 | Descriptor data |
| rspValid | output | 1 | Response pulse |
| rspFault | output | 1 | Response is a fault |
| rspCause | output | 3 | Cause code (0 = ok) |
| rspAddr | output | PA_W | Physical address, or request address on a fault |

## Verification
The bench builds the walker with four streams and a 40-bit physical address. That makes bypass, disabled, translating and bypass-plus-enable streams all reachable in one run. A behavioural descriptor memory holds a first-level table, several leaf entries with varied windows, full-page flags and invalid slots. The bench sweeps granule offsets across every leaf, for both reads and writes, so the inclusive edges of each window are hit. It also aims addresses at each base word, at missing first-level entries and at empty leaf slots, so every cause code and its memory-read count is checked.

// File: rtl/iommu_walk_pkg.sv
package iommu_walk_pkg;
  localparam int PAGE_SHIFT = 14;
  localparam int DESC_LOG = 3;
  localparam int IDX_W = PAGE_SHIFT - DESC_LOG;
  localparam int NUM_BASES = 4;
  localparam int SEL_W = $clog2(NUM_BASES);
  localparam int DVA_W = PAGE_SHIFT + 2 * IDX_W + SEL_W;
  localparam int BASE_W = 32;
  localparam int BASE_VALID_BIT = 31;
  localparam int BASE_SHIFT = 12;
  localparam int SUB_LO = 2;
  localparam int SUB_W = PAGE_SHIFT - SUB_LO;
  localparam int START_LO = 52;
  localparam int END_LO = 40;
  localparam int DESC_W = 64;

  typedef enum logic [2:0] {
    CAUSE_OK       = 3'd0,
    CAUSE_NO_BASE  = 3'd1,
    CAUSE_NO_L1    = 3'd2,
    CAUSE_NO_LEAF  = 3'd3,
    CAUSE_RD_BOUND = 3'd4,
    CAUSE_WR_BOUND = 3'd5,
    CAUSE_OFF      = 3'd6
  } cause_e;

  typedef struct packed {
    logic   capReq;
    logic   rdL1;
    logic   rdL2;
    logic   latchTable;
    logic   finish;
    logic   pass;
    cause_e cause;
  } strobe_t;

  typedef struct packed {
    logic bypass;
    logic enable;
    logic baseOk;
    logic l1Ok;
    logic leafOk;
    logic inBounds;
    logic isWrite;
  } status_t;
endpackage

// File: rtl/iommu_walk_ctrl.sv
module iommu_walk_ctrl
  import iommu_walk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  input  logic    memRdValid,
  input  status_t stat,
  output strobe_t stb
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_WAIT1, S_ISSUE2, S_WAIT2} state_e;
  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    stb.cause = CAUSE_OK;
    nextState = state;
    reqReady  = (state == S_IDLE);
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.capReq = 1'b1;
          nextState  = S_CHECK;
        end
      end
      S_CHECK: begin
        if (stat.bypass) begin
          stb.finish = 1'b1;
          stb.pass   = 1'b1;
          nextState  = S_IDLE;
        end else if (!stat.enable) begin
          stb.finish = 1'b1;
          stb.cause  = CAUSE_OFF;
          nextState  = S_IDLE;
        end else if (!stat.baseOk) begin
          stb.finish = 1'b1;
          stb.cause  = CAUSE_NO_BASE;
          nextState  = S_IDLE;
        end else begin
          stb.rdL1  = 1'b1;
          nextState = S_WAIT1;
        end
      end
      S_WAIT1: begin
        if (memRdValid) begin
          if (!stat.l1Ok) begin
            stb.finish = 1'b1;
            stb.cause  = CAUSE_NO_L1;
            nextState  = S_IDLE;
          end else begin
            stb.latchTable = 1'b1;
            nextState      = S_ISSUE2;
          end
        end
      end
      S_ISSUE2: begin
        stb.rdL2  = 1'b1;
        nextState = S_WAIT2;
      end
      S_WAIT2: begin
        if (memRdValid) begin
          stb.finish = 1'b1;
          nextState  = S_IDLE;
          if (!stat.leafOk)        stb.cause = CAUSE_NO_LEAF;
          else if (!stat.inBounds) stb.cause = stat.isWrite ? CAUSE_WR_BOUND : CAUSE_RD_BOUND;
          else                     stb.cause = CAUSE_OK;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/iommu_walk_dp.sv
module iommu_walk_dp
  import iommu_walk_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int PA_W = 40,
  parameter int SID_W = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [SID_W-1:0]                       reqStream,
  input  logic [DVA_W-1:0]                       reqAddr,
  input  logic                                   reqWrite,
  input  logic [NUM_STREAMS-1:0]                 bypassEn,
  input  logic [NUM_STREAMS-1:0]                 xlateEn,
  input  logic [NUM_STREAMS*NUM_BASES*BASE_W-1:0] tableBase,
  input  logic [DESC_W-1:0]                      memRdData,
  input  strobe_t                                stb,
  output status_t                                stat,
  output logic                                   memRdEn,
  output logic [PA_W-1:0]                        memRdAddr,
  output logic                                   rspValid,
  output logic                                   rspFault,
  output logic [2:0]                             rspCause,
  output logic [PA_W-1:0]                        rspAddr
);
  localparam int BFIELD_W = PA_W - BASE_SHIFT;
  localparam int IDX_PAD = PA_W - IDX_W - DESC_LOG;

  logic [DVA_W-1:0] dvaQ;
  logic [SID_W-1:0] streamQ;
  logic             writeQ, bypQ, enQ;
  logic [PA_W-1:0]  tblAddrQ;

  logic [SEL_W-1:0]  baseSel;
  logic [BASE_W-1:0] baseWord;
  logic [IDX_W-1:0]  l1Idx, l2Idx;
  logic [PA_W-1:0]   l1EntAddr, leafAddr, passAddr, xlAddr;
  logic [SUB_W-1:0]  subPos, startB, endB;

  assign baseSel = dvaQ[DVA_W-1 -: SEL_W];
  assign l1Idx   = dvaQ[PAGE_SHIFT+IDX_W +: IDX_W];
  assign l2Idx   = dvaQ[PAGE_SHIFT +: IDX_W];

  always_comb baseWord = tableBase[(int'(streamQ) * NUM_BASES + int'(baseSel)) * BASE_W +: BASE_W];

  assign l1EntAddr = {baseWord[BFIELD_W-1:0], {BASE_SHIFT{1'b0}}}
                   + {{IDX_PAD{1'b0}}, l1Idx, {DESC_LOG{1'b0}}};
  assign leafAddr  = tblAddrQ + {{IDX_PAD{1'b0}}, l2Idx, {DESC_LOG{1'b0}}};

  assign memRdEn   = stb.rdL1 | stb.rdL2;
  assign memRdAddr = stb.rdL2 ? leafAddr : l1EntAddr;

  assign subPos = dvaQ[PAGE_SHIFT-1:SUB_LO];
  assign startB = memRdData[START_LO +: SUB_W];
  assign endB   = memRdData[END_LO +: SUB_W];

  generate
    if (DVA_W >= PA_W) begin : g_trunc
      assign passAddr = dvaQ[PA_W-1:0];
    end else begin : g_ext
      assign passAddr = {{(PA_W-DVA_W){1'b0}}, dvaQ};
    end
  endgenerate

  assign xlAddr = {memRdData[PA_W-1:PAGE_SHIFT], dvaQ[PAGE_SHIFT-1:0]};

  always_comb begin
    stat.bypass   = bypQ;
    stat.enable   = enQ;
    stat.baseOk   = baseWord[BASE_VALID_BIT];
    stat.l1Ok     = &memRdData[1:0];
    stat.leafOk   = memRdData[0];
    stat.inBounds = memRdData[1] | ((subPos >= startB) && (subPos <= endB));
    stat.isWrite  = writeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dvaQ     <= '0;
      streamQ  <= '0;
      writeQ   <= 1'b0;
      bypQ     <= 1'b0;
      enQ      <= 1'b0;
      tblAddrQ <= '0;
    end else begin
      if (stb.capReq) begin
        dvaQ    <= reqAddr;
        streamQ <= reqStream;
        writeQ  <= reqWrite;
        bypQ    <= bypassEn[reqStream];
        enQ     <= xlateEn[reqStream];
      end
      if (stb.latchTable)
        tblAddrQ <= {memRdData[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspCause <= 3'd0;
      rspAddr  <= '0;
    end else begin
      rspValid <= stb.finish;
      if (stb.finish) begin
        rspCause <= stb.cause;
        rspFault <= (stb.cause != CAUSE_OK);
        if (stb.cause != CAUSE_OK || stb.pass) rspAddr <= passAddr;
        else                                  rspAddr <= xlAddr;
      end
    end
  end
endmodule

// File: rtl/iommu_walker.sv
module iommu_walker
  import iommu_walk_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int PA_W = 40,
  localparam int SID_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    reqValid,
  output logic                                    reqReady,
  input  logic [SID_W-1:0]                        reqStream,
  input  logic [DVA_W-1:0]                        reqAddr,
  input  logic                                    reqWrite,
  input  logic [NUM_STREAMS-1:0]                  bypassEn,
  input  logic [NUM_STREAMS-1:0]                  xlateEn,
  input  logic [NUM_STREAMS*NUM_BASES*BASE_W-1:0] tableBase,
  output logic                                    memRdEn,
  output logic [PA_W-1:0]                         memRdAddr,
  input  logic                                    memRdValid,
  input  logic [DESC_W-1:0]                       memRdData,
  output logic                                    rspValid,
  output logic                                    rspFault,
  output logic [2:0]                              rspCause,
  output logic [PA_W-1:0]                         rspAddr
);
  strobe_t stb;
  status_t stat;

  iommu_walk_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .memRdValid(memRdValid), .stat(stat), .stb(stb)
  );

  iommu_walk_dp #(.NUM_STREAMS(NUM_STREAMS), .PA_W(PA_W), .SID_W(SID_W)) dpI (
    .clk(clk), .rstN(rstN), .reqStream(reqStream), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .bypassEn(bypassEn), .xlateEn(xlateEn),
    .tableBase(tableBase), .memRdData(memRdData), .stb(stb), .stat(stat),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .rspValid(rspValid),
    .rspFault(rspFault), .rspCause(rspCause), .rspAddr(rspAddr)
  );
endmodule

// File: rtl/iommu_walk_chk.sv
module iommu_walk_chk
  import iommu_walk_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int PA_W = 40,
  localparam int SID_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   reqReady,
  input logic [SID_W-1:0]       reqStream,
  input logic [DVA_W-1:0]       reqAddr,
  input logic [NUM_STREAMS-1:0] bypassEn,
  input logic [NUM_STREAMS-1:0] xlateEn,
  input logic                   memRdEn,
  input logic                   rspValid,
  input logic                   rspFault,
  input logic [2:0]             rspCause,
  input logic [PA_W-1:0]        rspAddr
);
  logic accepted;
  assign accepted = reqValid && reqReady;

  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) memRdEn |=> !memRdEn);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) rspValid |=> !rspValid);

  // R10
  busy_rd_chk: assert property (@(posedge clk) disable iff (!rstN) memRdEn |-> !reqReady);

  // R2
  bypass_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && bypassEn[reqStream]) |-> ##2
    (rspValid && !rspFault && rspAddr == PA_W'($past(reqAddr, 2))));

  // R3
  off_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !bypassEn[reqStream] && !xlateEn[reqStream]) |-> ##2
    (rspValid && rspFault && rspCause == 3'd6));
endmodule

bind iommu_walker iommu_walk_chk #(.NUM_STREAMS(NUM_STREAMS), .PA_W(PA_W)) chkI (.*);

// File: tb/iommu_walker_test.sv
module iommu_walker_test;
  localparam int NS = 4;
  localparam int PAW = 40;
  localparam int DVAW = 38;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqStream = '0;
  logic [DVAW-1:0] reqAddr = '0;
  logic reqWrite = 1'b0;
  logic [NS-1:0] bypassEn, xlateEn;
  logic [NS*4*32-1:0] tableBase;
  logic memRdEn;
  logic [PAW-1:0] memRdAddr;
  logic memRdValid = 1'b0;
  logic [63:0] memRdData = '0;
  logic rspValid, rspFault;
  logic [2:0] rspCause;
  logic [PAW-1:0] rspAddr;

  logic [63:0] mem [logic [PAW-1:0]];
  logic [31:0] baseW [NS][4];

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  iommu_walker #(.NUM_STREAMS(NS), .PA_W(PAW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqStream(reqStream), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .bypassEn(bypassEn), .xlateEn(xlateEn), .tableBase(tableBase),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .rspValid(rspValid), .rspFault(rspFault),
    .rspCause(rspCause), .rspAddr(rspAddr)
  );

  always @(posedge clk) begin
    memRdValid <= memRdEn;
    if (memRdEn) memRdData <= mem.exists(memRdAddr) ? mem[memRdAddr] : 64'd0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      nFails++;
      $display("FAIL watchdog act=%0d exp=<190000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  function automatic logic [63:0] rdMem(input logic [PAW-1:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Reference walk written from the requirements.
  task automatic refWalk(input int s, input logic [DVAW-1:0] dva, input bit wr,
                         output int cause, output logic [PAW-1:0] pa,
                         output int reads, output string tag);
    logic [31:0] bw;
    logic [63:0] e1, e2;
    logic [PAW-1:0] a1, a2;
    logic [11:0] sub;
    pa = {2'b00, dva};
    reads = 0;
    cause = 0;
    if (bypassEn[s]) begin tag = "R2"; return; end
    if (!xlateEn[s]) begin cause = 6; tag = "R3"; return; end
    bw = baseW[s][dva[37:36]];
    if (!bw[31]) begin cause = 1; tag = "R4"; return; end
    a1 = {bw[27:0], 12'd0} + {29'd0, dva[35:25]} * 8;
    e1 = rdMem(a1);
    reads = 1;
    if (e1[1:0] != 2'b11) begin cause = 2; tag = "R5"; return; end
    a2 = {e1[39:14], 14'd0} + {29'd0, dva[24:14]} * 8;
    e2 = rdMem(a2);
    reads = 2;
    if (!e2[0]) begin cause = 3; tag = "R6"; return; end
    sub = dva[13:2];
    if (!e2[1] && (sub < e2[63:52] || sub > e2[51:40])) begin
      cause = wr ? 5 : 4; tag = "R8"; return;
    end
    tag = e2[1] ? "R9" : "R7";
    pa = {e2[39:14], dva[13:0]};
  endtask

  task automatic runReq(input int s, input logic [DVAW-1:0] dva, input bit wr);
    int eCause, eReads, reads, waitC;
    logic [PAW-1:0] eAddr;
    string tag;
    refWalk(s, dva, wr, eCause, eAddr, eReads, tag);
    @(negedge clk);
    reqValid = 1'b1; reqStream = 2'(s); reqAddr = dva; reqWrite = wr;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reads = 0;
    waitC = 1;
    while (!rspValid && waitC < 40) begin
      if (memRdEn) reads++;
      @(negedge clk);
      waitC++;
    end
    chk("R10", "response", 64'(rspValid), 64'd1);
    chk(tag, "cause", 64'(rspCause), 64'(eCause));
    chk("R11", "fault", 64'(rspFault), 64'(eCause != 0));
    chk((eCause != 0) ? "R11" : tag, "addr", 64'(rspAddr), 64'(eAddr));
    chk("R10", "reads", 64'(reads), 64'(eReads));
    if (eReads == 0) chk(tag, "latency", 64'(waitC), 64'd2);
    @(negedge clk);
    chk("R10", "pulse", 64'(rspValid), 64'd0);
  endtask

  initial begin
    bypassEn = 4'b1001;
    xlateEn  = 4'b1100;
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < 4; i++) baseW[s][i] = 32'd0;
    baseW[2][0] = 32'h8000_0100;
    baseW[2][2] = 32'h8000_0300;
    baseW[2][3] = 32'h8000_0100;
    baseW[3][0] = 32'h8000_0100;
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < 4; i++) tableBase[(s*4+i)*32 +: 32] = baseW[s][i];

    mem[40'h10_0000] = 64'h20_0003;
    mem[40'h10_0008] = 64'h24_0001;
    mem[40'h10_0010] = 64'h28_0003;
    for (int k = 0; k < 16; k++) begin
      logic [63:0] e;
      if (k % 5 != 4) begin
        e = 64'h40_0000_0000 + 64'(k) * 64'h8000;
        e[63:52] = 12'(k * 3);
        e[51:40] = 12'(12'hFFF - k * 5);
        e[1] = (k % 4 == 1);
        e[0] = 1'b1;
        if (k == 6) begin e[63:52] = 12'h100; e[51:40] = 12'h100; end
        mem[40'h20_0000 + 40'(k) * 8] = e;
      end
    end

    // R1 reset state
    @(negedge clk);
    chk("R1", "reqReady", 64'(reqReady), 64'd1);
    chk("R1", "rspValid", 64'(rspValid), 64'd0);
    chk("R1", "memRdEn", 64'(memRdEn), 64'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reqReady after", 64'(reqReady), 64'd1);
    chk("R1", "rspValid after", 64'(rspValid), 64'd0);

    // R2 bypass, including stream with both bits set
    runReq(0, 38'h0, 1'b0);
    runReq(0, 38'h3F_FFFF_FFFF, 1'b1);
    runReq(0, 38'h12_3456_789A, 1'b0);
    runReq(3, 38'h00_0000_4010, 1'b0);
    // R3 disabled stream
    runReq(1, 38'h00_0000_4010, 1'b0);
    runReq(1, 38'h3F_0000_0000, 1'b1);
    // R4 invalid base words (sel 1)
    runReq(2, {2'd1, 36'h0_0000_4010}, 1'b0);
    // R5 missing first-level: idx 1 (bad code), empty table via sel 2
    runReq(2, {2'd0, 11'd1, 11'd0, 14'h10}, 1'b0);
    runReq(2, {2'd2, 11'd0, 11'd0, 14'h10}, 1'b1);
    // R6 empty leaf table and empty slots
    runReq(2, {2'd0, 11'd2, 11'd0, 14'h10}, 1'b0);
    runReq(2, {2'd0, 11'd0, 11'd2047, 14'h10}, 1'b0);
    // R4 sel 3 reaches the same tables
    runReq(2, {2'd3, 11'd0, 11'd3, 14'h3FFC}, 1'b0);

    // R7 R8 R9 sweep over leaf slots and granule offsets
    for (int k = 0; k < 16; k++) begin
      int st, en;
      st = (k == 6) ? 256 : k * 3;
      en = (k == 6) ? 256 : 4095 - k * 5;
      for (int sub = 0; sub < 4096; sub += 61) begin
        runReq(2, {2'd0, 11'd0, 11'(k), 12'(sub), 2'(k)}, sub[0]);
      end
      for (int d = -1; d <= 1; d++) begin
        if (st + d >= 0) begin
          runReq(2, {2'd0, 11'd0, 11'(k), 12'(st + d), 2'd0}, 1'b0);
          runReq(2, {2'd0, 11'd0, 11'(k), 12'(st + d), 2'd3}, 1'b1);
        end
        if (en + d <= 4095) begin
          runReq(2, {2'd0, 11'd0, 11'(k), 12'(en + d), 2'd1}, 1'b1);
          runReq(2, {2'd0, 11'd0, 11'(k), 12'(en + d), 2'd2}, 1'b0);
        end
      end
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule